// File: doc/BRIEF.md
# Digital Pass-Array Regulator Controller with Setpoint Memory

This block is the digital side of a hybrid regulator whose pass device is an array of parallel PMOS switches. Each clock it reads a one-bit comparator decision, `cmp_low`, which is high when the regulated output sits below the reference the block drives. From that decision it steps a saturating up/down counter whose bits are the switch enables. It also drives the reference code for the comparator and an enable for the analog error loop that finishes the regulation.

Calibration is started with a pulse. It walks the reference code upward from zero to the top code. For each code it waits until the comparator decision has settled into a steady toggle, then stores the count in a small per-code table. After the last code the block moves to the requested setpoint. When the comparator first reports the output above the reference, the block freezes the counter and hands regulation to the analog loop.

A later change of setpoint, or a return from sleep, preloads the counter from the table in a single cycle. This brings the output close to its target at once, before the same handover takes place.

Top module: `ldo_dig_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, all outputs clear on that edge: `pmos_en`=0, `ref_code`=0, `analog_en`=0, `mode`=0, `cal_done`=0.
- R2: In calibrating and digital modes, the count rises by one per cycle when `cmp_low`=1 and falls by one when `cmp_low`=0. It holds at 0 and at 2^CNT_W-1 and never wraps.
- R3: A `start_cal` pulse in idle mode enters calibrating mode with `ref_code`=0 and count 0. `analog_en` stays 0 for the whole of calibration.
- R4: A code is settled in the cycle where `cmp_low` has differed from its previous-cycle value for the fourth cycle in a row. In that cycle the current count is stored for the current code, the count holds, and `ref_code` moves up by one.
- R5: The table holds one count per reference code. Every restore loads the entry of the requested code into `pmos_en`.
- R6: Storing the entry of the top code ends calibration. On the next edge `cal_done` is 1 for exactly one cycle, the mode is digital, `ref_code` equals `setpoint`, and the count equals that setpoint's entry.
- R7: In digital mode, with no sleep request and no setpoint change, `cmp_low`=0 enters analog mode. `analog_en` rises and the count is held for as long as analog mode lasts.
- R8: In digital or analog mode, a `setpoint` different from `ref_code` causes a restore: the mode becomes digital, `analog_en` becomes 0 and `ref_code` takes the new setpoint. A restore takes priority over the analog handover.
- R9: `sleep_req` in digital or analog mode enters sleep mode, with all enables and `analog_en` at 0. Sleep takes priority over a setpoint change on the same edge, and the table contents are kept.
- R10: When `sleep_req` falls in sleep mode, the block restores the current setpoint's entry and enters digital mode.
- R11: `mode` is encoded as idle=0, calibrating=1, digital=2, analog=3, sleep=4.
- R12: `sleep_req` is ignored in idle and calibrating modes, and `start_cal` is ignored outside idle mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_cal | input | 1 | Starts the calibration sweep (idle mode only) |
| sleep_req | input | 1 | Level request for sleep mode |
| setpoint | input | CODE_W | Requested reference code |
| cmp_low | input | 1 | Comparator decision: 1 means output below reference |
| pmos_en | output | CNT_W | Enables for the PMOS switch array (counter value) |
| ref_code | output | CODE_W | Reference code driven to the comparator's DAC |
| analog_en | output | 1 | Enable for the analog error loop |
| mode | output | 3 | Current operating mode |
| cal_done | output | 1 | One-cycle pulse when calibration ends |

## Verification
Two functions can collide on one edge. In analog mode a sleep request can arrive together with a setpoint change. In digital mode a setpoint change can arrive on the same cycle the comparator reports the output above the reference. The bench raises both inputs in the same cycle and checks the next cycle's mode, count and reference code. Sleep must win in the first case and the restore must win over the handover in the second, as judged by a behavioural model that also tracks the settle-detection history and the calibration table.

// File: rtl/ldo_ctrl_pkg.sv
package ldo_ctrl_pkg;
  typedef enum logic [2:0] {
    M_IDLE  = 3'd0,
    M_CAL   = 3'd1,
    M_DIG   = 3'd2,
    M_ANA   = 3'd3,
    M_SLEEP = 3'd4
  } mode_t;
endpackage

// File: rtl/ldo_step.sv
module ldo_step #(
  parameter int W = 8
) (
  input  logic [W-1:0] cur,
  input  logic         up,
  output logic [W-1:0] nxt
);
  localparam logic [W-1:0] TOP = '1;

  always_comb begin
    if (up) nxt = (cur == TOP)  ? cur : cur + W'(1);
    else    nxt = (cur == '0)   ? cur : cur - W'(1);
  end
endmodule

// File: rtl/ldo_settle_det.sv
module ldo_settle_det #(
  parameter int SETTLE = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic clr,
  input  logic cmp,
  output logic hit
);
  localparam int ALT_W = $clog2(SETTLE + 1);
  localparam logic [ALT_W-1:0] LAST = ALT_W'(SETTLE - 1);

  logic             prev_q;
  logic             have_q;
  logic [ALT_W-1:0] alt_q;
  logic             differ;

  assign differ = have_q && (cmp != prev_q);
  assign hit    = en && differ && (alt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr || !en) begin
      prev_q <= 1'b0;
      have_q <= 1'b0;
      alt_q  <= '0;
    end else begin
      prev_q <= cmp;
      have_q <= 1'b1;
      alt_q  <= differ ? alt_q + ALT_W'(1) : '0;
    end
  end

  // R4: the alternation run never reaches SETTLE without being cleared
  a_r4_run_bounded: assert property (@(posedge clk) disable iff (rst)
    en |-> (alt_q < ALT_W'(SETTLE)));
  // R4: a detected settle restarts the run
  a_r4_hit_restarts: assert property (@(posedge clk) disable iff (rst)
    (hit && clr) |=> (alt_q == '0 && !have_q));
endmodule

// File: rtl/ldo_cal_table.sv
module ldo_cal_table #(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];

  // R5: a stored count is readable at its code on the following cycle
  a_r5_write_lands: assert property (@(posedge clk) disable iff (rst)
    we |=> (mem[$past(waddr)] == $past(wdata)));
endmodule

// File: rtl/ldo_dig_ctrl.sv
module ldo_dig_ctrl
  import ldo_ctrl_pkg::*;
#(
  parameter int CODE_W = 4,
  parameter int CNT_W  = 8,
  parameter int SETTLE = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_cal,
  input  logic              sleep_req,
  input  logic [CODE_W-1:0] setpoint,
  input  logic              cmp_low,
  output logic [CNT_W-1:0]  pmos_en,
  output logic [CODE_W-1:0] ref_code,
  output logic              analog_en,
  output logic [2:0]        mode,
  output logic              cal_done
);
  localparam logic [CODE_W-1:0] CODE_TOP = '1;
  localparam logic [CNT_W-1:0]  CNT_TOP  = '1;

  mode_t             mode_q, mode_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d, step_v, rd_v, restore_v;
  logic [CODE_W-1:0] ref_q, ref_d;
  logic              ana_q, ana_d, done_q, done_d;
  logic              hit, tab_we, in_cal;

  assign in_cal = (mode_q == M_CAL);

  ldo_step #(.W(CNT_W)) u_step (
    .cur (cnt_q),
    .up  (cmp_low),
    .nxt (step_v)
  );

  ldo_settle_det #(.SETTLE(SETTLE)) u_det (
    .clk (clk),
    .rst (rst),
    .en  (in_cal),
    .clr (tab_we),
    .cmp (cmp_low),
    .hit (hit)
  );

  ldo_cal_table #(.AW(CODE_W), .DW(CNT_W)) u_tab (
    .clk   (clk),
    .rst   (rst),
    .we    (tab_we),
    .waddr (ref_q),
    .wdata (cnt_q),
    .raddr (setpoint),
    .rdata (rd_v)
  );

  // forward a same-cycle write so the last code restores its fresh entry
  assign restore_v = (tab_we && ref_q == setpoint) ? cnt_q : rd_v;

  always_comb begin
    mode_d = mode_q;
    cnt_d  = cnt_q;
    ref_d  = ref_q;
    ana_d  = ana_q;
    done_d = 1'b0;
    tab_we = 1'b0;
    unique case (mode_q)
      M_IDLE: if (start_cal) begin
        mode_d = M_CAL;
        ref_d  = '0;
        cnt_d  = '0;
      end
      M_CAL: if (hit) begin
        tab_we = 1'b1;
        if (ref_q == CODE_TOP) begin
          mode_d = M_DIG;
          done_d = 1'b1;
          ref_d  = setpoint;
          cnt_d  = restore_v;
        end else begin
          ref_d  = ref_q + CODE_W'(1);
        end
      end else begin
        cnt_d = step_v;
      end
      M_DIG: if (sleep_req) begin
        mode_d = M_SLEEP;
        cnt_d  = '0;
      end else if (setpoint != ref_q) begin
        ref_d  = setpoint;
        cnt_d  = restore_v;
      end else if (!cmp_low) begin
        mode_d = M_ANA;
        ana_d  = 1'b1;
      end else begin
        cnt_d = step_v;
      end
      M_ANA: if (sleep_req) begin
        mode_d = M_SLEEP;
        cnt_d  = '0;
        ana_d  = 1'b0;
      end else if (setpoint != ref_q) begin
        mode_d = M_DIG;
        ref_d  = setpoint;
        cnt_d  = restore_v;
        ana_d  = 1'b0;
      end
      M_SLEEP: if (!sleep_req) begin
        mode_d = M_DIG;
        ref_d  = setpoint;
        cnt_d  = restore_v;
      end
      default: mode_d = M_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= M_IDLE;
      cnt_q  <= '0;
      ref_q  <= '0;
      ana_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
      cnt_q  <= cnt_d;
      ref_q  <= ref_d;
      ana_q  <= ana_d;
      done_q <= done_d;
    end
  end

  assign pmos_en   = cnt_q;
  assign ref_code  = ref_q;
  assign analog_en = ana_q;
  assign mode      = mode_q;
  assign cal_done  = done_q;

  // R9: sleep drives every enable low
  a_r9_sleep_quiet: assert property (@(posedge clk) disable iff (rst)
    (mode_q == M_SLEEP) |-> (pmos_en == '0 && !analog_en));
  // R3: the analog loop stays off through calibration
  a_r3_cal_no_analog: assert property (@(posedge clk) disable iff (rst)
    (mode_q == M_CAL) |-> !analog_en);
  // R6: done lasts one cycle and lands in digital mode
  a_r6_done_single: assert property (@(posedge clk) disable iff (rst)
    cal_done |=> !cal_done);
  a_r6_done_digital: assert property (@(posedge clk) disable iff (rst)
    cal_done |-> (mode_q == M_DIG));
  // R2: the counter holds at its top value instead of wrapping
  a_r2_no_wrap: assert property (@(posedge clk) disable iff (rst)
    (mode_q == M_DIG && cmp_low && !sleep_req && setpoint == ref_q
     && cnt_q == CNT_TOP) |=> (cnt_q == CNT_TOP));
  // R7: analog mode freezes the count while undisturbed
  a_r7_analog_hold: assert property (@(posedge clk) disable iff (rst)
    (mode_q == M_ANA && !sleep_req && setpoint == ref_q)
      |=> ($stable(cnt_q) && analog_en));
  // R12: idle stays idle without a calibration request
  a_r12_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (mode_q == M_IDLE && !start_cal) |=> (mode_q == M_IDLE));
endmodule

// File: tb/ldo_dig_ctrl_bench.sv
module ldo_dig_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CODES = 16;
  localparam int CMAX = 255;
  localparam int WATCHDOG = 20000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_cal = 1'b0;
  logic       sleep_req = 1'b0;
  logic [3:0] setpoint = 4'd5;
  logic       force_en = 1'b1;
  logic       force_val = 1'b0;
  logic       cmp_low;
  logic [7:0] pmos_en;
  logic [3:0] ref_code;
  logic       analog_en;
  logic [2:0] mode;
  logic       cal_done;

  int n_checks = 0;
  int n_fail = 0;
  int cyc = 0;

  // model state
  int m_mode = 0, m_cnt = 0, m_ref = 0, m_ana = 0, m_done = 0;
  int m_prev = 0, m_have = 0, m_run = 0;
  int m_tab[CODES];

  function automatic int tgt(input int c);
    return 9 * c + 12;
  endfunction

  // plant: output below the reference while the enable count is under target
  assign cmp_low = force_en ? force_val : (int'(pmos_en) < tgt(int'(ref_code)));

  always #(CLK_PERIOD / 2) clk = ~clk;

  ldo_dig_ctrl u_ldo_dig_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start_cal (start_cal),
    .sleep_req (sleep_req),
    .setpoint  (setpoint),
    .cmp_low   (cmp_low),
    .pmos_en   (pmos_en),
    .ref_code  (ref_code),
    .analog_en (analog_en),
    .mode      (mode),
    .cal_done  (cal_done)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  function automatic int sat(input int v);
    if (v > CMAX) return CMAX;
    if (v < 0) return 0;
    return v;
  endfunction

  // behavioural reference, advanced on each rising edge
  always @(posedge clk) begin
    int c, sp, nrun;
    cyc++;
    c  = int'(cmp_low);
    sp = int'(setpoint);
    if (rst) begin
      m_mode = 0; m_cnt = 0; m_ref = 0; m_ana = 0; m_done = 0;
      m_have = 0; m_run = 0; m_prev = 0;
      foreach (m_tab[i]) m_tab[i] = 0;
    end else begin
      m_done = 0;
      case (m_mode)
        0: if (start_cal) begin
          m_mode = 1; m_ref = 0; m_cnt = 0; m_have = 0; m_run = 0;
        end
        1: begin
          nrun = (m_have != 0 && c != m_prev) ? m_run + 1 : 0;
          if (nrun == 4) begin
            m_tab[m_ref] = m_cnt;
            m_have = 0; m_run = 0;
            if (m_ref == CODES - 1) begin
              m_mode = 2; m_done = 1; m_ref = sp; m_cnt = m_tab[sp];
            end else m_ref++;
          end else begin
            m_prev = c; m_have = 1; m_run = nrun;
            m_cnt = sat(m_cnt + (c != 0 ? 1 : -1));
          end
        end
        2: if (sleep_req) begin
          m_mode = 4; m_cnt = 0;
        end else if (sp != m_ref) begin
          m_ref = sp; m_cnt = m_tab[sp];
        end else if (c == 0) begin
          m_mode = 3; m_ana = 1;
        end else m_cnt = sat(m_cnt + 1);
        3: if (sleep_req) begin
          m_mode = 4; m_cnt = 0; m_ana = 0;
        end else if (sp != m_ref) begin
          m_mode = 2; m_ref = sp; m_cnt = m_tab[sp]; m_ana = 0;
        end
        4: if (!sleep_req) begin
          m_mode = 2; m_ref = sp; m_cnt = m_tab[sp];
        end
        default: m_mode = 0;
      endcase
    end
    if (cyc > WATCHDOG) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      report();
    end
  end

  // compare every output against the model away from the rising edge
  always @(negedge clk) begin
    chk("R2 pmos_en vs model", int'(pmos_en), m_cnt);
    chk("R3 ref_code vs model", int'(ref_code), m_ref);
    chk("R7 analog_en vs model", int'(analog_en), m_ana);
    chk("R11 mode vs model", int'(mode), m_mode);
    chk("R6 cal_done vs model", int'(cal_done), m_done);
  end

  initial begin
    int seen;
    repeat (3) @(negedge clk);
    chk("R1 reset pmos_en", int'(pmos_en), 0);
    chk("R1 reset ref_code", int'(ref_code), 0);
    chk("R1 reset analog_en", int'(analog_en), 0);
    chk("R1 reset mode", int'(mode), 0);
    chk("R1 reset cal_done", int'(cal_done), 0);
    rst = 1'b0;

    sleep_req = 1'b1;
    repeat (3) @(negedge clk);
    chk("R12 sleep ignored in idle", int'(mode), 0);
    sleep_req = 1'b0;

    start_cal = 1'b1;
    @(negedge clk);
    start_cal = 1'b0;
    chk("R3 calibration entered", int'(mode), 1);
    chk("R3 first code zero", int'(ref_code), 0);

    force_val = 1'b0;
    repeat (4) @(negedge clk);
    chk("R2 floor holds at zero", int'(pmos_en), 0);

    force_en = 1'b0;
    sleep_req = 1'b1;
    start_cal = 1'b1;
    repeat (10) @(negedge clk);
    chk("R12 sleep and start ignored in calibration", int'(mode), 1);
    chk("R3 analog off during calibration", int'(analog_en), 0);
    sleep_req = 1'b0;
    start_cal = 1'b0;

    seen = 0;
    for (int k = 0; k < 6000 && seen == 0; k++) begin
      @(negedge clk);
      if (cal_done) seen = 1;
    end
    chk("R6 calibration finished", seen, 1);
    chk("R6 digital after calibration", int'(mode), 2);
    chk("R6 ref follows setpoint", int'(ref_code), 5);
    chk("R4 recorded value for code 5", int'(pmos_en), tgt(5) - 1);
    @(negedge clk);
    chk("R6 done is a single pulse", int'(cal_done), 0);
    repeat (3) @(negedge clk);
    chk("R7 handover to analog", int'(mode), 3);
    chk("R7 analog enabled", int'(analog_en), 1);
    chk("R7 count frozen at handover", int'(pmos_en), tgt(5));

    for (int c = 0; c < CODES; c++) begin
      setpoint = 4'(c);
      @(negedge clk);
      chk("R8 restore enters digital", int'(mode), 2);
      chk("R8 analog dropped on restore", int'(analog_en), 0);
      chk("R5 restored entry", int'(pmos_en), tgt(c) - 1);
      repeat (3) @(negedge clk);
      chk("R7 analog after restore", int'(mode), 3);
    end

    sleep_req = 1'b1;
    setpoint = 4'd3;
    @(negedge clk);
    chk("R9 sleep wins over setpoint change", int'(mode), 4);
    chk("R9 enables off in sleep", int'(pmos_en), 0);
    chk("R9 analog off in sleep", int'(analog_en), 0);
    chk("R9 ref kept in sleep", int'(ref_code), 15);
    repeat (5) @(negedge clk);
    sleep_req = 1'b0;
    @(negedge clk);
    chk("R10 wake enters digital", int'(mode), 2);
    chk("R10 wake ref", int'(ref_code), 3);
    chk("R10 wake restores kept entry", int'(pmos_en), tgt(3) - 1);

    force_en = 1'b1;
    force_val = 1'b0;
    setpoint = 4'd7;
    @(negedge clk);
    chk("R8 restore wins over handover", int'(mode), 2);
    chk("R8 restore ref", int'(ref_code), 7);
    chk("R5 restored entry code 7", int'(pmos_en), tgt(7) - 1);
    @(negedge clk);
    chk("R7 handover after restore", int'(mode), 3);

    force_val = 1'b1;
    setpoint = 4'd8;
    repeat (300) @(negedge clk);
    chk("R2 ceiling holds at top", int'(pmos_en), CMAX);
    chk("R2 still digital at ceiling", int'(mode), 2);
    force_val = 1'b0;
    @(negedge clk);
    chk("R7 handover from ceiling", int'(mode), 3);
    force_val = 1'b1;
    repeat (3) @(negedge clk);
    chk("R7 count held in analog", int'(pmos_en), CMAX);

    report();
  end
endmodule